// File: doc/BRIEF.md
# Bit-Serial Reciprocal Square Root and Reciprocal Unit

This block is a shared, multi-cycle arithmetic engine. For an unsigned fixed-point operand X it returns either Y = 1/sqrt(X) or Y = 1/X. It settles the result one bit per clock, starting at the most significant bit and working down. At each bit position it sets the bit on trial and tests the relation M·Y² ≤ 1, where M is X for the reciprocal square root and X² for the reciprocal. The bit stays set only if the test holds. Because both operations share this single trial-and-compare datapath, one instance can serve both kinds of request in turn.

A request is a one-cycle `start` pulse with `opcode` and `xIn` valid. The unit raises `busy` and, after exactly YW clock cycles whatever the operand, pulses `done` with the result on `yOut`. The result stays on `yOut` until the next operation completes. X is an XW-bit integer read as raw/2^XF. Y is a YW-bit integer read as raw/2^YF. The defaults are XW=16, XF=8, YW=16 and YF=12. The test is evaluated at full product width, so no rounding error enters the compare.

Top module: `rsqrt_recip_unit`

## Requirements
- R1: With opcode 0, yOut is the largest YW-bit value Y such that xIn·Y² ≤ 2^(XF+2·YF) (X·Y² ≤ 1 in real terms). Examples at the defaults: xIn=1024 gives 2048, and xIn=512 gives 2896.
- R2: With opcode 1, yOut is the largest YW-bit value Y such that xIn·Y ≤ 2^(XF+YF), which is the same condition as X²·Y² ≤ 1. Examples: xIn=768 gives 1365, and xIn=4096 gives 256.
- R3: If the all-ones Y still meets the condition of the selected operation, yOut is all ones (saturation). Examples: opcode 1 with xIn=16, and opcode 0 with xIn=1.
- R4: done is asserted exactly YW clock edges after the edge that accepted start, for every operand and opcode.
- R5: busy is high from the edge after an accepted start until the edge that raises done. done is high for one cycle only, and busy is low whenever done is high.
- R6: A start while busy is high is ignored. The running operation keeps its result and its latency.
- R7: If xIn is 0, the operation completes with yOut all ones and errOut high. errOut is low when a nonzero operand completes.
- R8: yOut and errOut change only in a cycle in which done is high. Between completions they hold their values, even when xIn and opcode change.
- R9: After reset, busy, done, yOut and errOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| opcode | input | 1 | 0 = reciprocal square root, 1 = reciprocal |
| xIn | input | XW | Unsigned operand, XF fraction bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| yOut | output | YW | Result, YF fraction bits, held between completions |
| errOut | output | 1 | Zero-operand flag, valid with done and held |

## Verification
The checker samples xIn and opcode only on the edge that accepts start, and it derives the best-fit bound for each completed result from that sample. This relies on the operand being meaningful only at acceptance, so the bench presents a new xIn and opcode together with start, then changes them freely while the unit is busy or idle. The latency property assumes that a start arrives only after reset has been released. The bench therefore issues every request after reset and never pulses reset in the middle of an operation.

// File: rtl/rsqrt_recip_pkg.sv
package rsqrt_recip_pkg;

  typedef enum logic {
    OP_RSQRT = 1'b0,
    OP_RECIP = 1'b1
  } opSel_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operand, clear working result
    logic step;   // decide one result bit
    logic last;   // current step decides bit 0
  } ctrlStrobe_t;

endpackage

// File: rtl/rsqrt_recip_ctrl.sv
module rsqrt_recip_ctrl
  import rsqrt_recip_pkg::*;
#(
  parameter int YW = 16,
  localparam int IW = (YW > 1) ? $clog2(YW) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] bitIdx,
  output ctrlStrobe_t   ctrl
);

  logic          running;
  logic [IW-1:0] bitCnt;

  always_comb begin
    ctrl.load = start && !running;
    ctrl.step = running;
    ctrl.last = running && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      bitCnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctrl.last;
      if (ctrl.load) begin
        running <= 1'b1;
        bitCnt  <= IW'(YW - 1);
      end else if (running) begin
        if (bitCnt == '0) running <= 1'b0;
        else              bitCnt  <= bitCnt - 1'b1;
      end
    end
  end

  assign busy   = running;
  assign bitIdx = bitCnt;

endmodule

// File: rtl/rsqrt_recip_datapath.sv
module rsqrt_recip_datapath
  import rsqrt_recip_pkg::*;
#(
  parameter int XW = 16,
  parameter int XF = 8,
  parameter int YW = 16,
  parameter int YF = 12,
  localparam int IW = (YW > 1) ? $clog2(YW) : 1,
  localparam int MW = 2 * XW,          // scaled operand, 2*XF fraction bits
  localparam int SW = 2 * YW,          // trial square
  localparam int PW = MW + SW,         // full product width
  localparam int ONE_SH = 2 * XF + 2 * YF
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   ctrl,
  input  logic [IW-1:0] bitIdx,
  input  opSel_t        opSel,
  input  logic [XW-1:0] xIn,
  output logic [YW-1:0] yOut,
  output logic          errOut
);

  localparam logic [PW-1:0] UNITY = PW'(1) << ONE_SH;

  logic [MW-1:0] mReg;
  logic [YW-1:0] workY;
  logic          zeroFlag;

  logic [YW-1:0] trialY;
  logic [SW-1:0] trialSq;
  logic [PW-1:0] prod;
  logic          keepBit;
  logic [YW-1:0] nextY;
  logic [MW-1:0] mLoad;

  // Operand scaling: reciprocal squares X, reciprocal root shifts X to the same scale
  always_comb begin
    if (opSel == OP_RECIP) mLoad = MW'(xIn) * MW'(xIn);
    else                   mLoad = MW'(xIn) << XF;
  end

  // Trial-and-compare for the current bit
  always_comb begin
    trialY  = workY | (YW'(1) << bitIdx);
    trialSq = SW'(trialY) * SW'(trialY);
    prod    = PW'(mReg) * PW'(trialSq);
    keepBit = (prod <= UNITY);
    nextY   = keepBit ? trialY : workY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg     <= '0;
      workY    <= '0;
      zeroFlag <= 1'b0;
      yOut     <= '0;
      errOut   <= 1'b0;
    end else begin
      if (ctrl.load) begin
        mReg     <= mLoad;
        workY    <= '0;
        zeroFlag <= (xIn == '0);
      end else if (ctrl.step) begin
        workY <= nextY;
        if (ctrl.last) begin
          yOut   <= nextY;
          errOut <= zeroFlag;
        end
      end
    end
  end

endmodule

// File: rtl/rsqrt_recip_unit.sv
module rsqrt_recip_unit
  import rsqrt_recip_pkg::*;
#(
  parameter int XW = 16,
  parameter int XF = 8,
  parameter int YW = 16,
  parameter int YF = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          opcode,
  input  logic [XW-1:0] xIn,
  output logic          busy,
  output logic          done,
  output logic [YW-1:0] yOut,
  output logic          errOut
);

  localparam int IW = (YW > 1) ? $clog2(YW) : 1;

  ctrlStrobe_t   ctrl;
  logic [IW-1:0] bitIdx;
  opSel_t        opSel;

  assign opSel = opSel_t'(opcode);

  rsqrt_recip_ctrl #(.YW(YW)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .bitIdx (bitIdx),
    .ctrl   (ctrl)
  );

  rsqrt_recip_datapath #(.XW(XW), .XF(XF), .YW(YW), .YF(YF)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .bitIdx (bitIdx),
    .opSel  (opSel),
    .xIn    (xIn),
    .yOut   (yOut),
    .errOut (errOut)
  );

endmodule

// File: rtl/rsqrt_recip_unit_chk.sv
module rsqrt_recip_unit_chk #(
  parameter int XW = 16,
  parameter int XF = 8,
  parameter int YW = 16,
  parameter int YF = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          opcode,
  input logic [XW-1:0] xIn,
  input logic          busy,
  input logic          done,
  input logic [YW-1:0] yOut,
  input logic          errOut
);

  localparam int CW = $clog2(YW + 2) + 1;
  localparam int FW = XW + 2 * (YW + 1) + 2;

  logic [CW-1:0] latCnt;
  logic          armed;
  logic [XW-1:0] capX;
  logic          capOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= '0;
      armed  <= 1'b0;
      capX   <= '0;
      capOp  <= 1'b0;
    end else if (start && !busy) begin
      latCnt <= '0;
      armed  <= 1'b1;
      capX   <= xIn;
      capOp  <= opcode;
    end else if (armed) begin
      latCnt <= latCnt + 1'b1;
      if (done) armed <= 1'b0;
    end
  end

  function automatic logic fitsY(input logic [YW:0] y);
    logic [FW-1:0] px;
    px = FW'(capX) * FW'(y);
    if (capOp) return px <= (FW'(1) << (XF + YF));
    return (px * FW'(y)) <= (FW'(1) << (XF + 2 * YF));
  endfunction

  // R1 / R2: completed result is the largest value meeting the bound
  p_best_fit_r1: assert property (@(posedge clk) disable iff (!rstN)
    (done && !errOut) |-> (fitsY({1'b0, yOut}) &&
                           ((&yOut) || !fitsY({1'b0, yOut} + 1'b1))));

  // R3: saturate when the all-ones value still satisfies the bound
  p_saturate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && fitsY({1'b0, {YW{1'b1}}})) |-> (&yOut));

  // R4 and R6: fixed latency counted from the accepting edge; a restart would break it
  p_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (armed && latCnt == CW'(YW)));

  // R5: single-cycle done, busy clear at completion
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7: zero operand flagged and saturated, nonzero not flagged
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && capX == '0) |-> (errOut && (&yOut)));
  p_nonzero_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && capX != '0) |-> !errOut);

  // R8: outputs move only with done
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(yOut) && $stable(errOut)));

endmodule

bind rsqrt_recip_unit rsqrt_recip_unit_chk #(.XW(XW), .XF(XF), .YW(YW), .YF(YF)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .opcode (opcode),
  .xIn    (xIn),
  .busy   (busy),
  .done   (done),
  .yOut   (yOut),
  .errOut (errOut)
);

// File: tb/rsqrt_recip_unit_test.sv
module rsqrt_recip_unit_test;

  localparam int XW = 16;
  localparam int XF = 8;
  localparam int YW = 16;
  localparam int YF = 12;
  localparam int NV = 20;

  // {opcode, xIn, expected yOut, expected errOut}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 16'd256,   16'd4096,  1'b0},
    {1'b1, 16'd256,   16'd4096,  1'b0},
    {1'b0, 16'd1024,  16'd2048,  1'b0},
    {1'b1, 16'd1024,  16'd1024,  1'b0},
    {1'b0, 16'd4096,  16'd1024,  1'b0},
    {1'b1, 16'd4096,  16'd256,   1'b0},
    {1'b0, 16'd64,    16'd8192,  1'b0},
    {1'b1, 16'd64,    16'd16384, 1'b0},
    {1'b0, 16'd16,    16'd16384, 1'b0},
    {1'b1, 16'd16,    16'hFFFF,  1'b0},
    {1'b0, 16'd512,   16'd2896,  1'b0},
    {1'b1, 16'd512,   16'd2048,  1'b0},
    {1'b0, 16'd768,   16'd2364,  1'b0},
    {1'b1, 16'd768,   16'd1365,  1'b0},
    {1'b0, 16'hFFFF,  16'd256,   1'b0},
    {1'b1, 16'hFFFF,  16'd16,    1'b0},
    {1'b0, 16'd1,     16'hFFFF,  1'b0},
    {1'b1, 16'd1,     16'hFFFF,  1'b0},
    {1'b0, 16'd0,     16'hFFFF,  1'b1},
    {1'b1, 16'd0,     16'hFFFF,  1'b1}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          opcode = 1'b0;
  logic [XW-1:0] xIn = '0;
  logic          busy;
  logic          done;
  logic [YW-1:0] yOut;
  logic          errOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rsqrt_recip_unit #(.XW(XW), .XF(XF), .YW(YW), .YF(YF)) uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .xIn(xIn),
    .busy(busy), .done(done), .yOut(yOut), .errOut(errOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit fits(input logic op, input longint unsigned x,
                              input longint unsigned y);
    if (op) return (x * y) <= (64'd1 << (XF + YF));
    return (x * y * y) <= (64'd1 << (XF + 2 * YF));
  endfunction

  function automatic logic [15:0] model(input logic op, input logic [15:0] x);
    real xr, yr;
    longint unsigned y;
    if (x == 0) return 16'hFFFF;
    xr = real'(x) / 256.0;
    yr = op ? (4096.0 / xr) : (4096.0 / $sqrt(xr));
    if (yr > 65535.0) yr = 65535.0;
    y = longint'($floor(yr));
    while (y < 65535 && fits(op, x, y + 1)) y++;
    while (y > 0 && !fits(op, x, y)) y--;
    return y[15:0];
  endfunction

  task automatic runOp(input logic op, input logic [15:0] x, input string req,
                       output logic [15:0] y, output logic e);
    int lat;
    @(negedge clk);
    opcode = op; xIn = x; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (lat == 2) chk(busy == 1'b1, "R5", "busy during op", busy, 1);
    end while (!done && lat < 100);
    chk(lat == YW, "R4", "latency", lat, YW);
    chk(busy == 1'b0, "R5", "busy at done", busy, 0);
    y = yOut; e = errOut;
    @(negedge clk);
    chk(done == 1'b0, "R5", "done one cycle", done, 0);
    chk(yOut == y, req, "result held", yOut, y);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] y;
    logic e;
    logic [15:0] lfsr;
    logic [15:0] held;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(busy == 1'b0,   "R9", "busy after reset", busy, 0);
    chk(done == 1'b0,   "R9", "done after reset", done, 0);
    chk(yOut == '0,     "R9", "yOut after reset", yOut, 0);
    chk(errOut == 1'b0, "R9", "errOut after reset", errOut, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table: R1, R2, R3, R7
    for (int i = 0; i < NV; i++) begin
      string req;
      logic vOp; logic [15:0] vX, vY; logic vE;
      {vOp, vX, vY, vE} = VEC[i];
      if (vE) req = "R7";
      else if (vY == 16'hFFFF) req = "R3";
      else if (vOp) req = "R2";
      else req = "R1";
      runOp(vOp, vX, req, y, e);
      chk(y == vY, req, $sformatf("yOut vec %0d", i), y, vY);
      chk(e == vE, "R7", $sformatf("errOut vec %0d", i), e, vE);
    end

    // Pseudo-random operands against the bound model: R1, R2
    lfsr = 16'hACE1;
    for (int i = 0; i < 24; i++) begin
      logic op;
      logic [15:0] ey;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = lfsr[0];
      ey = model(op, lfsr);
      runOp(op, lfsr, op ? "R2" : "R1", y, e);
      chk(y == ey, op ? "R2" : "R1", $sformatf("sweep x=%0d", lfsr), y, ey);
    end

    // R6: start while busy is ignored
    @(negedge clk);
    opcode = 1'b0; xIn = 16'd1024; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (3) @(posedge clk);
    #1 opcode = 1'b1; xIn = 16'd16; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    begin
      int lat;
      lat = 4;
      do begin
        @(posedge clk); lat++;
        @(negedge clk);
      end while (!done && lat < 100);
      chk(lat == YW, "R6", "latency with ignored start", lat, YW);
      chk(yOut == 16'd2048, "R6", "result with ignored start", yOut, 2048);
    end

    // R8: outputs hold while idle with changing inputs, and during the next op
    @(negedge clk);
    held = yOut;
    for (int i = 0; i < 5; i++) begin
      opcode = i[0]; xIn = 16'(i * 977 + 3);
      @(negedge clk);
    end
    chk(yOut == held, "R8", "yOut held while idle", yOut, held);
    opcode = 1'b1; xIn = 16'd768; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (8) @(negedge clk);
    chk(yOut == held, "R8", "yOut held during op", yOut, held);
    chk(errOut == 1'b0, "R8", "errOut held during op", errOut, 0);
    while (!done) @(negedge clk);
    chk(yOut == 16'd1365, "R2", "result after hold test", yOut, 1365);

    // R7: error flag clears on next nonzero completion
    runOp(1'b0, 16'd0, "R7", y, e);
    chk(e == 1'b1, "R7", "err set", e, 1);
    runOp(1'b0, 16'd256, "R7", y, e);
    chk(e == 1'b0, "R7", "err cleared", e, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule